// File: doc/BRIEF.md
# Iterative multiply-divide unit

This block performs 32-bit integer multiply, multiply-accumulate and divide beside a pipelined integer datapath. An operation is offered with an operation code, two operands and a signed/unsigned flag. It is taken on any clock edge where `op_valid` is high. The issuing side is never held back, because `op_ready` stays high. The unit then works for a fixed number of cycles while the caller carries on with independent work. Multiply and multiply-accumulate build the product one multiplier bit per clock. Divide retires two quotient bits per clock and then waits, so that both kinds of operation end after a fixed count.

Results go into a pair of 32-bit result registers, HI and LO. A multiply leaves its 64-bit product there. A multiply-accumulate adds its product to the pair's earlier contents. A divide leaves the quotient in LO and the remainder in HI. A consumer reads either register through a separate read port. That port raises a stall request while an operation is in flight, so a dependent instruction waits only until the value is final. Software can also load HI or LO directly through write ports, but only while the unit is idle. No rounding, saturation or scaling is applied to any result.

Top module: `imd_unit`

## Requirements
- R1: Operation code 2'b00 (multiply) leaves the full 64-bit product of `op_a` and `op_b` with the upper half in HI and the lower half in LO. Operands are two's complement when `op_signed` is 1 and unsigned when it is 0. No rounding or saturation is applied.
- R2: Operation code 2'b01 (multiply-accumulate) leaves {HI,LO} equal to the earlier {HI,LO} plus the 64-bit product, modulo 2^64.
- R3: Operation code 2'b10 (divide) leaves the quotient, truncated toward zero, in LO and the remainder in HI. In signed mode the remainder takes the sign of the dividend, and -2^31 / -1 gives quotient 0x80000000 and remainder 0.
- R4: A divide by zero raises no error: LO becomes 0xFFFFFFFF and HI becomes the dividend.
- R5: A multiply or multiply-accumulate taken at a clock edge keeps `busy` high for the next 32 cycles. Its result lands in HI/LO at the 32nd following rising edge, and `done` is high for exactly the one cycle after that edge.
- R6: A divide behaves the same way with a count of 25 cycles.
- R7: `op_ready` is always high. An offer with operation code 2'b11 is not taken and changes neither `busy` nor HI/LO.
- R8: `rd_data` returns HI when `rd_sel` is 1 and LO when `rd_sel` is 0. `rd_stall` is high exactly when `rd_req` is high while `busy` is high. HI and LO keep their earlier values until an operation completes.
- R9: An operation offered while another is in flight aborts the old one. The old result is never written and never signalled, and the cycle count restarts for the new operation.
- R10: `wr_hi_en`/`wr_lo_en` load `wr_data` into HI/LO at the clock edge only while `busy` is low, and have no effect while it is high. A write in the same idle cycle as a multiply-accumulate offer is included in that accumulation.
- R11: After reset HI and LO are zero and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation offered this cycle |
| op_ready | output | 1 | Always high; offers are never refused |
| op_code | input | 2 | 00 multiply, 01 multiply-accumulate, 10 divide, 11 none |
| op_signed | input | 1 | 1 for two's complement operands |
| op_a | input | 32 | Multiplicand or dividend |
| op_b | input | 32 | Multiplier or divisor |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle pulse after the result lands |
| rd_req | input | 1 | A consumer wants a result register this cycle |
| rd_sel | input | 1 | 1 selects HI, 0 selects LO |
| rd_data | output | 32 | Selected result register |
| rd_stall | output | 1 | Consumer must wait; the value is not final |
| wr_hi_en | input | 1 | Load HI from `wr_data` (idle only) |
| wr_lo_en | input | 1 | Load LO from `wr_data` (idle only) |
| wr_data | input | 32 | Direct write data |

## Verification
Two events can collide in one clock edge, and the bench drives both on purpose. In the first, a direct write to HI/LO lands in the same idle cycle that a multiply-accumulate is offered, so the accumulation must start from the freshly written pair. In the second, a new operation is offered on the very edge where the running one would finish, or a write is attempted in that final busy cycle, so the old result must not land and the write must be dropped. Directed cases stage these collisions at fixed cycles. A long stretch of random offers, writes and reads then lands them at every phase of the count. On every clock a behavioural reference model judges `busy`, `done`, `rd_stall` and the selected register against what the requirements allow.

// File: rtl/imd_pkg.sv
// Package imd_pkg
// Shared operation encoding for the iterative multiply-divide unit.
// Assumes a two-bit operation code field at the unit's boundary.
package imd_pkg;
    typedef enum logic [1:0] {
        IMD_MUL = 2'b00,
        IMD_MAC = 2'b01,
        IMD_DIV = 2'b10,
        IMD_NOP = 2'b11
    } imd_op_e;
endpackage

// File: rtl/imd_seq.sv
// Module imd_seq
// Cycle sequencer: loads the latency of the accepted operation, counts it
// down and flags the edge at which the result must be committed.
// Assumes a start always wins over a finish in the same cycle (abort).
module imd_seq #(
    parameter int MUL_CYCLES = 32,
    parameter int DIV_CYCLES = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_is_div,
    output logic busy,
    output logic finish
);
    localparam int MAXC = (MUL_CYCLES > DIV_CYCLES) ? MUL_CYCLES : DIV_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;

    // Load the count on start, count down while busy, drop busy at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= start_is_div ? CW'(DIV_CYCLES) : CW'(MUL_CYCLES);
        end else if (busy_q) begin
            if (cnt_q == CW'(1)) busy_q <= 1'b0;
            cnt_q <= cnt_q - CW'(1);
        end
    end

    // Commit strobe: last counted cycle that is not displaced by a restart.
    always_comb begin
        busy   = busy_q;
        finish = busy_q && (cnt_q == CW'(1)) && !start;
    end
endmodule

// File: rtl/imd_mul.sv
// Module imd_mul
// Shift-and-add multiplier on operand magnitudes, one multiplier bit per
// clock, with sign correction and accumulation applied to the final step.
// Assumes the sequencer gives at least XLEN cycles between load and commit;
// the last partial step is formed combinationally at the commit edge.
module imd_mul #(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              sgn,
    input  logic [XLEN-1:0]   a,
    input  logic [XLEN-1:0]   b,
    input  logic [2*XLEN-1:0] base,
    output logic [2*XLEN-1:0] result
);
    localparam int PW = 2 * XLEN;
    localparam int LW = $clog2(XLEN + 1);

    logic [XLEN-1:0] ma_q;
    logic [PW-1:0]   p_q;
    logic [PW-1:0]   base_q;
    logic            neg_q;
    logic [LW-1:0]   left_q;

    logic [XLEN:0]   addend;
    logic [XLEN:0]   sum;
    logic [PW-1:0]   p_step;
    logic [PW-1:0]   signed_prod;

    function automatic logic [XLEN-1:0] magn(input logic [XLEN-1:0] v, input logic s);
        return (s && v[XLEN-1]) ? -v : v;
    endfunction

    // Capture operands on load, then advance one multiplier bit per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ma_q   <= '0;
            p_q    <= '0;
            base_q <= '0;
            neg_q  <= 1'b0;
            left_q <= '0;
        end else if (load) begin
            ma_q   <= magn(a, sgn);
            p_q    <= {{XLEN{1'b0}}, magn(b, sgn)};
            base_q <= base;
            neg_q  <= sgn && (a[XLEN-1] ^ b[XLEN-1]);
            left_q <= LW'(XLEN - 1);
        end else if (left_q != '0) begin
            p_q    <= p_step;
            left_q <= left_q - LW'(1);
        end
    end

    // One add-and-shift step, then sign fix and accumulation of the total.
    always_comb begin
        addend      = p_q[0] ? {1'b0, ma_q} : '0;
        sum         = {1'b0, p_q[PW-1:XLEN]} + addend;
        p_step      = {sum, p_q[XLEN-1:1]};
        signed_prod = neg_q ? -p_step : p_step;
        result      = base_q + signed_prod;
    end
endmodule

// File: rtl/imd_div.sv
// Module imd_div
// Restoring divider on operand magnitudes retiring BPS quotient bits per
// clock, with sign correction and divide-by-zero values at the output.
// Assumes XLEN is a multiple of BPS and XLEN/BPS steps fit before commit.
module imd_div #(
    parameter int XLEN = 32,
    parameter int BPS  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            sgn,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] quot,
    output logic [XLEN-1:0] remd
);
    localparam int STEPS = XLEN / BPS;
    localparam int LW    = $clog2(STEPS + 1);

    logic [XLEN-1:0] dvs_q, quo_q, rem_q, a_raw_q;
    logic            negq_q, negr_q, dz_q;
    logic [LW-1:0]   left_q;

    logic [XLEN-1:0] quo_n, rem_n;
    logic [XLEN:0]   trial, diff;
    logic            ge;

    function automatic logic [XLEN-1:0] magn(input logic [XLEN-1:0] v, input logic s);
        return (s && v[XLEN-1]) ? -v : v;
    endfunction

    // Capture operands on load, then retire BPS quotient bits per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvs_q   <= '0;
            quo_q   <= '0;
            rem_q   <= '0;
            a_raw_q <= '0;
            negq_q  <= 1'b0;
            negr_q  <= 1'b0;
            dz_q    <= 1'b0;
            left_q  <= '0;
        end else if (load) begin
            dvs_q   <= magn(b, sgn);
            quo_q   <= magn(a, sgn);
            rem_q   <= '0;
            a_raw_q <= a;
            negq_q  <= sgn && (a[XLEN-1] ^ b[XLEN-1]);
            negr_q  <= sgn && a[XLEN-1];
            dz_q    <= (b == '0);
            left_q  <= LW'(STEPS);
        end else if (left_q != '0) begin
            quo_q  <= quo_n;
            rem_q  <= rem_n;
            left_q <= left_q - LW'(1);
        end
    end

    // BPS chained restoring subtract-and-shift steps in one cycle.
    always_comb begin
        quo_n = quo_q;
        rem_n = rem_q;
        trial = '0;
        diff  = '0;
        ge    = 1'b0;
        for (int i = 0; i < BPS; i++) begin
            trial = {rem_n, quo_n[XLEN-1]};
            ge    = (trial >= {1'b0, dvs_q});
            diff  = trial - {1'b0, dvs_q};
            rem_n = ge ? diff[XLEN-1:0] : trial[XLEN-1:0];
            quo_n = {quo_n[XLEN-2:0], ge};
        end
    end

    // Final quotient and remainder with sign fix and zero-divisor values.
    always_comb begin
        quot = dz_q ? '1      : (negq_q ? -quo_q : quo_q);
        remd = dz_q ? a_raw_q : (negr_q ? -rem_q : rem_q);
    end
endmodule

// File: rtl/imd_unit.sv
// Module imd_unit
// Top of the iterative multiply-divide unit: accepts operations without
// back-pressure, runs them in the multiplier or divider, commits into the
// HI/LO pair, serves a stalling read port and idle-only direct writes.
// Assumes the caller holds rd_req until rd_stall falls.
module imd_unit #(
    parameter int XLEN       = 32,
    parameter int MUL_CYCLES = 32,
    parameter int DIV_CYCLES = 25
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    output logic            op_ready,
    input  logic [1:0]      op_code,
    input  logic            op_signed,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    output logic            busy,
    output logic            done,
    input  logic            rd_req,
    input  logic            rd_sel,
    output logic [XLEN-1:0] rd_data,
    output logic            rd_stall,
    input  logic            wr_hi_en,
    input  logic            wr_lo_en,
    input  logic [XLEN-1:0] wr_data
);
    import imd_pkg::*;

    localparam int DIV_BPS = (XLEN + DIV_CYCLES - 2) / (DIV_CYCLES - 1);

    logic [XLEN-1:0]   hi_q, lo_q;
    logic [XLEN-1:0]   hi_w, lo_w;
    logic              done_q, cur_div_q;
    logic              start, is_div, finish, busy_int;
    logic [2*XLEN-1:0] mac_base, mul_res;
    logic [XLEN-1:0]   div_q, div_r;

    // Accept decode and the pair as seen after any idle direct write.
    always_comb begin
        start    = op_valid && (op_code != IMD_NOP);
        is_div   = (op_code == IMD_DIV);
        hi_w     = (wr_hi_en && !busy_int) ? wr_data : hi_q;
        lo_w     = (wr_lo_en && !busy_int) ? wr_data : lo_q;
        mac_base = (op_code == IMD_MAC) ? {hi_w, lo_w} : '0;
    end

    imd_seq #(.MUL_CYCLES(MUL_CYCLES), .DIV_CYCLES(DIV_CYCLES)) seq_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_is_div(is_div),
        .busy(busy_int), .finish(finish)
    );

    imd_mul #(.XLEN(XLEN)) mul_i (
        .clk(clk), .rst_n(rst_n), .load(start && !is_div), .sgn(op_signed),
        .a(op_a), .b(op_b), .base(mac_base), .result(mul_res)
    );

    imd_div #(.XLEN(XLEN), .BPS(DIV_BPS)) div_i (
        .clk(clk), .rst_n(rst_n), .load(start && is_div), .sgn(op_signed),
        .a(op_a), .b(op_b), .quot(div_q), .remd(div_r)
    );

    // Result pair: commit on finish, otherwise take idle direct writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q      <= '0;
            lo_q      <= '0;
            done_q    <= 1'b0;
            cur_div_q <= 1'b0;
        end else begin
            done_q <= finish;
            if (start) cur_div_q <= is_div;
            if (finish) begin
                {hi_q, lo_q} <= cur_div_q ? {div_r, div_q} : mul_res;
            end else begin
                hi_q <= hi_w;
                lo_q <= lo_w;
            end
        end
    end

    // Port outputs: never refuse an offer, stall readers while in flight.
    always_comb begin
        op_ready = 1'b1;
        busy     = busy_int;
        done     = done_q;
        rd_data  = rd_sel ? hi_q : lo_q;
        rd_stall = rd_req && busy_int;
    end
endmodule

// File: rtl/imd_unit_chk.sv
// Module imd_unit_chk
// Property checker bound to imd_unit; tracks the age of the last accepted
// operation with its own counter to check the commit latency.
module imd_unit_chk #(
    parameter int XLEN       = 32,
    parameter int MUL_CYCLES = 32,
    parameter int DIV_CYCLES = 25
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_valid,
    input logic [1:0]      op_code,
    input logic            busy,
    input logic            done,
    input logic            rd_stall,
    input logic [XLEN-1:0] hi_q,
    input logic [XLEN-1:0] lo_q
);
    logic       take;
    logic [7:0] age_q, lat_q;

    assign take = op_valid && (op_code != 2'b11);

    // Cycles elapsed since the most recent accepted operation (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= '0;
            lat_q <= '0;
        end else if (take) begin
            age_q <= '0;
            lat_q <= (op_code == 2'b10) ? 8'(DIV_CYCLES) : 8'(MUL_CYCLES);
        end else if (age_q != 8'hFF) begin
            age_q <= age_q + 8'd1;
        end
    end

    AST_HILO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(hi_q) && $stable(lo_q))); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (age_q == lat_q)); // R6
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> busy); // R9
    AST_NOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !take) |=> !busy); // R7
    AST_STALL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stall |-> busy); // R8
endmodule

bind imd_unit imd_unit_chk #(
    .XLEN(XLEN), .MUL_CYCLES(MUL_CYCLES), .DIV_CYCLES(DIV_CYCLES)
) chk_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .busy(busy), .done(done), .rd_stall(rd_stall), .hi_q(hi_q), .lo_q(lo_q)
);

// File: tb/imd_unit_tb_top.sv
// Bench for imd_unit: directed cases plus random traffic, all judged every
// clock against a behavioural reference model of the requirements.
module imd_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0, op_signed = 1'b0;
    logic [1:0]  op_code = 2'b00;
    logic [31:0] op_a = '0, op_b = '0, wr_data = '0;
    logic        rd_req = 1'b0, rd_sel = 1'b0, wr_hi_en = 1'b0, wr_lo_en = 1'b0;
    logic        op_ready, busy, done, rd_stall;
    logic [31:0] rd_data;

    int vectors = 0, miscompares = 0;
    bit finished = 1'b0, seen_edge = 1'b0;

    // Reference model state
    logic [31:0] m_hi = '0, m_lo = '0;
    logic [63:0] m_pend = '0;
    bit          m_busy = 1'b0, m_done = 1'b0;
    int          m_cnt = 0;

    always #10 clk = ~clk;

    imd_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
        .op_code(op_code), .op_signed(op_signed), .op_a(op_a), .op_b(op_b),
        .busy(busy), .done(done), .rd_req(rd_req), .rd_sel(rd_sel),
        .rd_data(rd_data), .rd_stall(rd_stall), .wr_hi_en(wr_hi_en),
        .wr_lo_en(wr_lo_en), .wr_data(wr_data)
    );

    function automatic logic [63:0] ref_calc(input logic [1:0] c, input logic s,
                                             input logic [31:0] a, b, input logic [63:0] base);
        longint sa, sb;
        logic [63:0] p;
        if (c == 2'b10) begin
            if (b == 0) return {a, 32'hFFFF_FFFF};
            if (s) begin
                sa = longint'($signed(a)); sb = longint'($signed(b));
                p = {64'(sa % sb) << 32} | {32'b0, 32'(sa / sb)};
                return p;
            end
            return {a % b, a / b};
        end
        if (s) p = 64'(longint'($signed(a)) * longint'($signed(b)));
        else   p = {32'b0, a} * {32'b0, b};
        return ((c == 2'b01) ? base : 64'd0) + p;
    endfunction

    // Reference model: advances on each rising edge from the sampled inputs.
    always @(posedge clk) begin
        bit st, fin;
        if (!rst_n) begin
            m_hi = '0; m_lo = '0; m_busy = 0; m_cnt = 0; m_done = 0;
        end else begin
            st  = op_valid && (op_code != 2'b11);
            fin = m_busy && (m_cnt == 1) && !st;
            m_done = fin;
            if (!m_busy) begin
                if (wr_hi_en) m_hi = wr_data;
                if (wr_lo_en) m_lo = wr_data;
            end
            if (fin) {m_hi, m_lo} = m_pend;
            if (st) begin
                m_pend = ref_calc(op_code, op_signed, op_a, op_b, {m_hi, m_lo});
                m_busy = 1;
                m_cnt  = (op_code == 2'b10) ? 25 : 32;
            end else if (m_busy) begin
                if (m_cnt == 1) m_busy = 0;
                m_cnt--;
            end
        end
        seen_edge = 1'b1;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (seen_edge && !finished) begin
            chk("R5/R6 busy", 64'(busy), 64'(m_busy));
            chk("R5/R6 done", 64'(done), 64'(m_done));
            chk("R7 op_ready", 64'(op_ready), 64'd1);
            chk("R8 rd_stall", 64'(rd_stall), 64'(rd_req && m_busy));
            chk("R8 rd_data", 64'(rd_data), 64'(rd_sel ? m_hi : m_lo));
        end
    end

    task automatic tick(); @(posedge clk); #2; endtask

    task automatic issue(input logic [1:0] c, input logic s, input logic [31:0] a, b);
        op_valid = 1; op_code = c; op_signed = s; op_a = a; op_b = b;
        tick();
        op_valid = 0;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        do begin tick(); n++; end while (!done && n < 100);
    endtask

    task automatic read_pair(input logic [63:0] exp, input string tag);
        rd_sel = 0; @(negedge clk); chk(tag, 64'(rd_data), 64'(exp[31:0])); tick();
        rd_sel = 1; @(negedge clk); chk(tag, 64'(rd_data), 64'(exp[63:32])); tick();
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog R5 actual=running expected=finished");
            finished = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) tick();
        rst_n = 1; tick();
        @(negedge clk); chk("R11 busy after reset", 64'(busy), 64'd0);
        chk("R11 done after reset", 64'(done), 64'd0); tick();
        read_pair(64'd0, "R11 reset HI/LO");

        issue(2'b00, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF); wait_done(n);
        chk("R5 multiply latency", 64'(n), 64'd32);
        read_pair(64'hFFFF_FFFE_0000_0001, "R1 unsigned product");
        issue(2'b00, 1, 32'd7, -32'sd3); wait_done(n);
        read_pair(64'hFFFF_FFFF_FFFF_FFEB, "R1 signed product");
        issue(2'b01, 1, 32'h0001_0000, 32'h0001_0000); wait_done(n);
        read_pair(64'h0000_0000_FFFF_FFEB, "R2 accumulate");

        issue(2'b10, 1, -32'sd7, 32'd2); wait_done(n);
        chk("R6 divide latency", 64'(n), 64'd25);
        read_pair(64'hFFFF_FFFF_FFFF_FFFD, "R3 signed divide");
        issue(2'b10, 0, 32'd100, 32'd7); wait_done(n);
        read_pair({32'd2, 32'd14}, "R3 unsigned divide");
        issue(2'b10, 1, 32'h8000_0000, 32'hFFFF_FFFF); wait_done(n);
        read_pair({32'd0, 32'h8000_0000}, "R3 overflow divide");
        issue(2'b10, 1, 32'h0000_1234, 32'd0); wait_done(n);
        read_pair({32'h0000_1234, 32'hFFFF_FFFF}, "R4 divide by zero");

        issue(2'b11, 0, 32'd5, 32'd5);
        @(negedge clk); chk("R7 no-op not taken", 64'(busy), 64'd0); tick();
        read_pair({32'h0000_1234, 32'hFFFF_FFFF}, "R7 no-op leaves pair");

        issue(2'b00, 0, 32'd9, 32'd9); repeat (4) tick();
        issue(2'b10, 0, 32'd100, 32'd7); wait_done(n);
        chk("R9 restart count", 64'(n), 64'd25);
        read_pair({32'd2, 32'd14}, "R9 restart result");

        issue(2'b00, 0, 32'd3, 32'd5);
        rd_req = 1; rd_sel = 0;
        @(negedge clk); chk("R8 stall in flight", 64'(rd_stall), 64'd1);
        chk("R8 old LO held", 64'(rd_data), 64'd14);
        wr_hi_en = 1; wr_data = 32'hDEAD; tick(); wr_hi_en = 0;
        wait_done(n);
        @(negedge clk); chk("R8 stall released", 64'(rd_stall), 64'd0);
        rd_req = 0; tick();
        read_pair(64'd15, "R10 busy write ignored");

        wr_hi_en = 1; wr_data = 32'hAAAA; tick(); wr_hi_en = 0;
        wr_lo_en = 1; wr_data = 32'h5555; tick(); wr_lo_en = 0;
        read_pair({32'hAAAA, 32'h5555}, "R10 idle writes");
        wr_hi_en = 1; wr_lo_en = 1; wr_data = 32'd5;
        issue(2'b01, 0, 32'd2, 32'd3);
        wr_hi_en = 0; wr_lo_en = 0; wait_done(n);
        read_pair({32'd5, 32'd11}, "R10 write with accumulate");

        for (int i = 0; i < 8000; i++) begin
            op_valid  = ($urandom_range(0, 19) == 0);
            op_code   = 2'($urandom_range(0, 3));
            op_signed = 1'($urandom_range(0, 1));
            op_a      = ($urandom_range(0, 7) == 0) ? 32'h8000_0000 : $urandom;
            op_b      = ($urandom_range(0, 7) == 0) ? 32'd0 : $urandom;
            wr_hi_en  = ($urandom_range(0, 9) == 0);
            wr_lo_en  = ($urandom_range(0, 9) == 0);
            wr_data   = $urandom;
            rd_req    = 1'($urandom_range(0, 1));
            rd_sel    = 1'($urandom_range(0, 1));
            tick();
        end
        op_valid = 0; wr_hi_en = 0; wr_lo_en = 0; rd_req = 0;
        repeat (40) tick();

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule